// File: doc/BRIEF.md
# Active Loopback Tamper Monitor

The block guards one or more conductive loops, such as enclosure switches or trace meshes, by driving a square wave into each loop and watching what returns. It runs from a slow always-on clock. While the monitor is enabled, each channel toggles its drive pin on every clock edge. The returning level passes through a synchronizer and is compared against the drive level, delayed by the same number of flops.

Consecutive compare results are grouped in pairs: one sample taken while the delayed drive is low, then one taken while it is high. Each pair is one check. A check fails if either of its samples disagrees with the drive. Pairing the samples this way means a loop stuck at either rail fails every check.

A channel lowers its active-low status only when two checks in a row have failed. A lone glitch therefore never raises an alarm. The falling edge of a status pin is the tamper event that a wake-up controller or interrupt logic would consume. A sticky summary flag records that any channel has fired.

Top module: `tamper_loop_monitor`

## Requirements
- R1: While rst_ni is low, every drive_o bit is 0, every status_no bit is 1 and tamper_seen_o is 0.
- R2: With en_i high at a rising edge, each drive_o bit inverts at that edge, so the drive runs at half the clock rate.
- R3: When a channel's loop_i follows its drive_o, that channel's status_no stays 1 indefinitely.
- R4: loop_i passes through SYNC_STAGES (default 2) flops and is compared against drive_o delayed by the same depth. A check is a low-drive sample followed by a high-drive sample, and it fails if either sample mismatches, so a loop stuck at 0 or at 1 fails every check.
- R5: status_no goes to 0 only after two consecutive checks have failed. A single mismatching sample (a one-cycle glitch) leaves status_no at 1 throughout.
- R6: If a loop becomes stuck at 0, stuck at 1, or inverted before rising edge k, the channel's status_no is still 1 after edge k+3 and is 0 after edge k+6 at the latest.
- R7: Channels are independent: a fault on one loop leaves the status_no of every other channel at 1.
- R8: While en_i is low, status_no is 1 with no clock delay, drive_o is 0 after the next rising edge, and check history is discarded, so re-enabling with an intact loop gives no alarm.
- R9: tamper_seen_o becomes 1 one cycle after any status_no bit falls, and then holds at 1 whatever en_i and the loops do, until rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable |
| loop_i | input | NUM_CH | Returned loop signal, one bit per channel |
| drive_o | output | NUM_CH | Square-wave drive into each loop |
| status_no | output | NUM_CH | Per-channel status; 0 means tamper |
| tamper_seen_o | output | 1 | Sticky flag: some channel has fired |

## Verification
- **Drive pins:** they change at the first edge after the stimulus.
- **Status pins:** they respond to en_i without any clock delay. A loop fault needs the synchronizer depth plus two completed checks to reach the status pin, which falls between four and six edges after the fault first meets an edge.
- **Summary flag:** it trails a status fall by exactly one edge.

The driver records each expectation against an absolute cycle number. It checks a fault window at its two ends: status still high after edge k+3, and low after edge k+6. The test therefore holds for either phase of the drive. The monitor samples a quarter period after the falling edge, once every input change made at that falling edge has settled.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int unsigned DEF_NUM_CH      = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic err_acc;  // mismatch seen in the low-drive half of the current check
    logic cur_ok;   // result of the latest completed check
    logic prev_ok;  // result of the check before it
  } chk_state_t;

  localparam chk_state_t CHK_IDLE = '{err_acc: 1'b0, cur_ok: 1'b1, prev_ok: 1'b1};
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= 1'b0;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
      assign q_o = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tamper_channel.sv
module tamper_channel
  import tamper_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic loop_i,
  output logic drive_o,
  output logic status_o,
  output logic fell_o
);
  logic drive_q, drive_d, loop_s, sample_ok, status_q;
  chk_state_t st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    drive_q <= 1'b0;
    else if (!en_i) drive_q <= 1'b0;
    else            drive_q <= ~drive_q;
  end
  assign drive_o = drive_q;

  // equal-depth paths keep drive and return aligned
  tamper_sync #(.STAGES(SYNC_STAGES)) u_sync_ret (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(loop_i), .q_o(loop_s));
  tamper_sync #(.STAGES(SYNC_STAGES)) u_dly_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(drive_q), .q_o(drive_d));

  assign sample_ok = ~(drive_d ^ loop_s);

  always_comb begin
    st_d = st_q;
    if (!en_i) begin
      st_d = CHK_IDLE;
    end else if (!drive_d) begin
      st_d.err_acc = ~sample_ok;
    end else begin
      st_d.cur_ok  = ~st_q.err_acc & sample_ok;
      st_d.prev_ok = st_q.cur_ok;
      st_d.err_acc = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CHK_IDLE;
    else         st_q <= st_d;
  end

  assign status_o = ~en_i | st_q.cur_ok | st_q.prev_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= 1'b1;
    else         status_q <= status_o;
  end
  assign fell_o = status_q & ~status_o;

  p_drive_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !drive_o);
  p_drive_toggle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> drive_o != $past(drive_o));
  p_fall_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> $past(en_i));
  p_two_fails_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o) |-> !$past(st_q.cur_ok));
endmodule

// File: rtl/tamper_loop_monitor.sv
module tamper_loop_monitor
  import tamper_pkg::*;
#(
  parameter int unsigned NUM_CH      = DEF_NUM_CH,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_CH-1:0] loop_i,
  output logic [NUM_CH-1:0] drive_o,
  output logic [NUM_CH-1:0] status_no,
  output logic              tamper_seen_o
);
  logic [NUM_CH-1:0] fell;
  logic              seen_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tamper_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .loop_i  (loop_i[c]),
        .drive_o (drive_o[c]),
        .status_o(status_no[c]),
        .fell_o  (fell[c])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= seen_q | (|fell);
  end
  assign tamper_seen_o = seen_q;

  p_flag_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fell) |=> tamper_seen_o);
  p_flag_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tamper_seen_o |=> tamper_seen_o);
endmodule

// File: tb/tb_tamper_loop_monitor.sv
module tb_tamper_loop_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0;
  logic [NCH-1:0] loop_w, drive_w, status_w;
  logic seen_w;
  logic [1:0] mode [NCH];  // 0 intact, 1 stuck0, 2 stuck1, 3 inverted

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    int    cyc;
    int    kind;  // 0 status, 1 flag, 2 drive
    int    ch;
    logic  val;
    string req;
  } exp_t;
  exp_t q[$];

  tamper_loop_monitor #(.NUM_CH(NCH), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .loop_i(loop_w),
    .drive_o(drive_w), .status_no(status_w), .tamper_seen_o(seen_w));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      case (mode[c])
        2'd0: loop_w[c] = drive_w[c];
        2'd1: loop_w[c] = 1'b0;
        2'd2: loop_w[c] = 1'b1;
        default: loop_w[c] = ~drive_w[c];
      endcase
    end
  end

  task automatic check(logic act, logic exp, string req, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cyc=%0d actual=%0b expected=%0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic push(int dcyc, int kind, int ch, logic val, string req);
    exp_t e;
    int idx;
    e.cyc = cyc + dcyc; e.kind = kind; e.ch = ch; e.val = val; e.req = req;
    idx = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].cyc > e.cyc) begin idx = i; break; end
    end
    q.insert(idx, e);
  endtask

  task automatic push_all_status(int dcyc, logic val, string req);
    for (int c = 0; c < NCH; c++) push(dcyc, 0, c, val, req);
  endtask

  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      case (e.kind)
        0: check(status_w[e.ch], e.val, e.req, $sformatf("status ch%0d", e.ch));
        1: check(seen_w, e.val, e.req, "tamper_seen");
        default: check(drive_w[e.ch], e.val, e.req, $sformatf("drive ch%0d", e.ch));
      endcase
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    int c0;
    for (int c = 0; c < NCH; c++) mode[c] = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    push_all_status(0, 1'b1, "R1");
    for (int c = 0; c < NCH; c++) push(0, 2, c, 1'b0, "R1");
    push(0, 1, 0, 1'b0, "R1");
    @(negedge clk) rst_ni = 1'b1;
    push(1, 2, 0, 1'b0, "R8");
    push(1, 0, 0, 1'b1, "R8");

    // R2 toggle, R3 intact loops stay quiet
    repeat (2) @(negedge clk);
    en = 1'b1;
    for (int i = 1; i <= 8; i++)
      for (int c = 0; c < NCH; c++) push(i, 2, c, logic'(i % 2), "R2");
    for (int i = 1; i <= 20; i++) push_all_status(i, 1'b1, "R3");
    repeat (22) @(negedge clk);

    // R5 single-sample glitch is filtered
    mode[0] = 2'd3;
    for (int i = 0; i <= 12; i++) push(i, 0, 0, 1'b1, "R5");
    @(negedge clk) mode[0] = 2'd0;
    repeat (14) @(negedge clk);

    // R6/R4 stuck-at-1 on ch1, R7 others quiet, R9 flag
    mode[1] = 2'd2;
    push(4, 0, 1, 1'b1, "R6");
    push(7, 0, 1, 1'b0, "R6");
    push(9, 0, 1, 1'b0, "R4");
    push(7, 0, 0, 1'b1, "R7");
    push(7, 0, 2, 1'b1, "R7");
    push(7, 0, 3, 1'b1, "R7");
    push(4, 1, 0, 1'b0, "R9");
    push(8, 1, 0, 1'b1, "R9");
    repeat (10) @(negedge clk);

    // R8 disable forces status high, drive low; R9 flag holds
    en = 1'b0;
    push(0, 0, 1, 1'b1, "R8");
    for (int i = 1; i <= 3; i++) push(i, 2, 1, 1'b0, "R8");
    push(1, 1, 0, 1'b1, "R9");
    push(4, 1, 0, 1'b1, "R9");
    repeat (5) @(negedge clk);
    mode[1] = 2'd0;
    @(negedge clk) en = 1'b1;
    for (int i = 1; i <= 15; i++) push(i, 0, 1, 1'b1, "R8");
    push(1, 2, 1, 1'b1, "R2");
    push(15, 1, 0, 1'b1, "R9");
    repeat (18) @(negedge clk);

    // R6 stuck-at-0 on ch2 and inverted loop on ch3, R7 others quiet
    mode[2] = 2'd1;
    mode[3] = 2'd3;
    c0 = cyc;
    push(4, 0, 2, 1'b1, "R6");
    push(4, 0, 3, 1'b1, "R6");
    push(7, 0, 2, 1'b0, "R6");
    push(7, 0, 3, 1'b0, "R6");
    push(7, 0, 0, 1'b1, "R7");
    push(7, 0, 1, 1'b1, "R7");
    repeat (10) @(negedge clk);

    // R1 reset clears the flag
    rst_ni = 1'b0;
    push(0, 1, 0, 1'b0, "R1");
    push_all_status(0, 1'b1, "R1");
    for (int c = 0; c < NCH; c++) push(0, 2, c, 1'b0, "R1");
    repeat (3) @(negedge clk);
    if (cyc < c0) $display("cycle counter error");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    report();
  end
endmodule